// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block holds the interrupt control and status word of a multi-channel DMA controller, together with the per-channel enable word that decides whether a channel may begin a transfer. The CPU writes 32-bit words into either register. The interrupt word keeps a small set of general control bits, a force bit, one enable bit per channel, a global enable, one latched completion flag per channel and a master flag. Each channel's transfer engine sends a one-cycle completion pulse. That pulse is latched as a flag only when the channel's enable bit is set. Software clears a flag by writing a 1 to its position.

The master flag is recomputed on every cycle from the newly computed register contents. It is the only source of the request toward the system interrupt controller. That request is a single-cycle pulse, issued only when the master flag goes from clear to set. A second function gates channel starts. A start request from a channel's control register goes through only when the matching enable bit in the channel enable word is set. Channel 5 has no hardware behind it. It can never latch a flag and never start.

All ports are plain control and status pins. Both writes are single-cycle strobes that always complete, so there is no back-pressure.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, the interrupt word and the channel enable word read as zero, `irq_pulse` is low and no start is granted.
- R2: An interrupt-word write stores `wr_data` under mask 0x00FF803F. This covers control bits 5:0, force bit 15, channel enables in bits 22:16 (channel i at bit 16+i) and global enable bit 23. Bits 14:6 always read 0, and the written value of bit 31 has no direct effect.
- R3: A completion pulse on `ch_done[i]` sets flag bit 24+i on the next cycle only if enable bit 16+i held 1 before that edge. Otherwise the pulse is ignored.
- R4: An interrupt-word write clears every flag whose bit is written as 1 and keeps every flag written as 0. A completion pulse on the same cycle wins over the clear.
- R5: Bit 31 (the master flag, also on `irq_master`) reads 1 exactly when (bit 23 and any flag in bits 30:24) or bit 15 holds in the same word. It follows a write or completion on the next cycle.
- R6: `irq_pulse` is high for one cycle, in the first cycle the master flag reads 1 after having read 0.
- R7: While the master flag stays set, further completions or writes raise no new `irq_pulse`.
- R8: `ch_start_go[i]` equals `ch_start_req[i]` AND bit 4*i+3 of the channel enable word, combinationally.
- R9: Channel 5 never sets its flag (bit 29) and never gets `ch_start_go[5]`, whatever its enables and requests.
- R10: A channel enable word write stores all 32 bits of `wr_data`, readable on `pcr_rd` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| icr_wr | input | 1 | Write strobe for the interrupt word |
| pcr_wr | input | 1 | Write strobe for the channel enable word |
| wr_data | input | 32 | Write data for either register |
| ch_start_req | input | 7 | Start bit from each channel's control register |
| ch_done | input | 7 | One-cycle completion pulse per channel |
| icr_rd | output | 32 | Current interrupt word |
| pcr_rd | output | 32 | Current channel enable word |
| irq_master | output | 1 | Master flag (bit 31) |
| irq_pulse | output | 1 | One-shot request toward the system interrupt controller |
| ch_start_go | output | 7 | Granted start per channel |

## Verification
The bench builds the block with its default of seven channels and channel 5 marked unused. At that size it is cheap to sweep all 128 enable words against all start requests. It can also sweep all 128 flag-enable patterns against a full burst of completions, which covers gating of every channel, including the unused one. A long pseudo-random run of mixed writes and completions follows. It is compared word for word against an arithmetic model, which exercises simultaneous set and clear, force-driven master flags, and the difference between holding the master flag and raising it again.

// File: rtl/dicr_pkg.sv
package dicr_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned CH_MAX     = 7;
  localparam logic [31:0] WR_MASK    = 32'h00FF_803F;
  localparam int unsigned LOW_W      = 6;
  localparam int unsigned FORCE_BIT  = 15;
  localparam int unsigned EN_LSB     = 16;
  localparam int unsigned GEN_BIT    = 23;
  localparam int unsigned FLG_LSB    = 24;
  localparam int unsigned MASTER_BIT = 31;
  localparam int unsigned PCR_STRIDE = 4;
  localparam int unsigned PCR_OFS    = 3;
endpackage

// File: rtl/dicr_flags.sv
module dicr_flags #(
  parameter int unsigned NCH = 7,
  parameter logic [NCH-1:0] USED = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] clr,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] done,
  output logic [NCH-1:0] flags_q,
  output logic [NCH-1:0] flags_n
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (USED[i]) begin : g_live
      always_comb flags_n[i] = (flags_q[i] & ~clr[i]) | (done[i] & en[i]);

      always_ff @(posedge clk) begin
        if (!rst_n) flags_q[i] <= 1'b0;
        else        flags_q[i] <= flags_n[i];
      end

      // R3
      done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done[i] && en[i]) |=> flags_q[i]);
      // R4
      w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !(done[i] && en[i])) |=> !flags_q[i]);
    end else begin : g_dead
      always_comb flags_n[i] = 1'b0;
      always_ff @(posedge clk) flags_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dicr_master.sv
module dicr_master (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_n,
  input  logic force_n,
  input  logic any_flag_n,
  output logic master_q,
  output logic pulse_q
);
  logic master_n;
  always_comb master_n = (gen_n & any_flag_n) | force_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      master_q <= master_n;
      pulse_q  <= master_n & ~master_q;
    end
  end

  // R7
  held_no_repulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_q |=> !pulse_q);
  // R6
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_q && master_n) |=> (pulse_q && master_q));
endmodule

// File: rtl/dicr_start_gate.sv
module dicr_start_gate
  import dicr_pkg::*;
#(
  parameter int unsigned NCH = 7,
  parameter logic [NCH-1:0] USED = '1
) (
  input  logic [WORD_W-1:0] pcr,
  input  logic [NCH-1:0]    req,
  output logic [NCH-1:0]    go
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int unsigned EBIT = PCR_STRIDE * i + PCR_OFS;
    if (USED[i]) begin : g_live
      always_comb go[i] = req[i] & pcr[EBIT];
    end else begin : g_dead
      always_comb go[i] = 1'b0;
    end
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dicr_pkg::*;
#(
  parameter int unsigned NCH = 7,
  parameter logic [NCH-1:0] CH_USED = 7'b101_1111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              icr_wr,
  input  logic              pcr_wr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [NCH-1:0]    ch_start_req,
  input  logic [NCH-1:0]    ch_done,
  output logic [WORD_W-1:0] icr_rd,
  output logic [WORD_W-1:0] pcr_rd,
  output logic              irq_master,
  output logic              irq_pulse,
  output logic [NCH-1:0]    ch_start_go
);
  // NCH may not exceed CH_MAX: the field layout reserves seven positions.
  logic [LOW_W-1:0] low_q, low_n;
  logic             force_q, force_n;
  logic             gen_q, gen_n;
  logic [NCH-1:0]   en_q, en_n;
  logic [NCH-1:0]   flags_q, flags_n, clr;
  logic [WORD_W-1:0] pcr_q;
  logic             master_q;

  always_comb begin
    low_n   = low_q;
    force_n = force_q;
    gen_n   = gen_q;
    en_n    = en_q;
    clr     = '0;
    if (icr_wr) begin
      low_n   = wr_data[LOW_W-1:0];
      force_n = wr_data[FORCE_BIT];
      gen_n   = wr_data[GEN_BIT];
      en_n    = wr_data[EN_LSB +: NCH];
      clr     = wr_data[FLG_LSB +: NCH];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q   <= '0;
      force_q <= 1'b0;
      gen_q   <= 1'b0;
      en_q    <= '0;
      pcr_q   <= '0;
    end else begin
      low_q   <= low_n;
      force_q <= force_n;
      gen_q   <= gen_n;
      en_q    <= en_n;
      if (pcr_wr) pcr_q <= wr_data;
    end
  end

  dicr_flags #(.NCH(NCH), .USED(CH_USED)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .en      (en_q),
    .done    (ch_done),
    .flags_q (flags_q),
    .flags_n (flags_n)
  );

  dicr_master u_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_n      (gen_n),
    .force_n    (force_n),
    .any_flag_n (|flags_n),
    .master_q   (master_q),
    .pulse_q    (irq_pulse)
  );

  dicr_start_gate #(.NCH(NCH), .USED(CH_USED)) u_gate (
    .pcr (pcr_q),
    .req (ch_start_req),
    .go  (ch_start_go)
  );

  always_comb begin
    icr_rd                    = '0;
    icr_rd[LOW_W-1:0]         = low_q;
    icr_rd[FORCE_BIT]         = force_q;
    icr_rd[EN_LSB +: NCH]     = en_q;
    icr_rd[GEN_BIT]           = gen_q;
    icr_rd[FLG_LSB +: NCH]    = flags_q;
    icr_rd[MASTER_BIT]        = master_q;
  end

  assign pcr_rd     = pcr_q;
  assign irq_master = master_q;

  // R5
  master_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_master == ((icr_rd[GEN_BIT] && |icr_rd[FLG_LSB +: NCH]) || icr_rd[FORCE_BIT]));
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    icr_rd[14:LOW_W] == '0);
  // R10
  pcr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcr_wr |=> pcr_rd == $past(wr_data));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R8
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_start_go[i] |-> (pcr_rd[PCR_STRIDE*i+PCR_OFS] && ch_start_req[i]));
    if (!CH_USED[i]) begin : g_dead
      // R9
      unused_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_start_go[i] && !icr_rd[FLG_LSB+i]);
    end
  end
endmodule

// File: tb/tb_dma_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dma_irq_ctrl;
  localparam logic [6:0] USED = 7'b101_1111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        icr_wr = 1'b0, pcr_wr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [6:0]  ch_start_req = '0, ch_done = '0;
  logic [31:0] icr_rd, pcr_rd;
  logic        irq_master, irq_pulse;
  logic [6:0]  ch_start_go;

  int checks = 0, errors = 0;
  logic [31:0] m_icr = '0, m_pcr = '0;
  logic        m_pulse = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  dma_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .icr_wr(icr_wr), .pcr_wr(pcr_wr), .wr_data(wr_data),
    .ch_start_req(ch_start_req), .ch_done(ch_done), .icr_rd(icr_rd), .pcr_rd(pcr_rd),
    .irq_master(irq_master), .irq_pulse(irq_pulse), .ch_start_go(ch_start_go)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] go_model(input logic [31:0] p, input logic [6:0] r);
    logic [6:0] g;
    for (int i = 0; i < 7; i++) g[i] = r[i] & p[4*i+3] & USED[i];
    return g;
  endfunction

  // one cycle: drive after negedge, update model, sample at following negedge
  task automatic step(input logic wi, input logic wp, input logic [31:0] wd,
                      input logic [6:0] dn, input logic [6:0] rq, input string tag);
    logic [31:0] base;
    logic [6:0]  fl;
    logic        ms;
    icr_wr = wi; pcr_wr = wp; wr_data = wd; ch_done = dn; ch_start_req = rq;
    fl = m_icr[30:24];
    if (wi) begin
      base = wd & 32'h00FF_803F;
      fl   = fl & ~wd[30:24];
    end else base = m_icr & 32'h00FF_803F;
    fl = fl | (dn & m_icr[22:16] & USED);
    ms = (base[23] && |fl) || base[15];
    m_pulse = ms && !m_icr[31];
    m_icr = base | {1'b0, fl, 24'h0} | {ms, 31'h0};
    if (wp) m_pcr = wd;
    @(posedge clk);
    @(negedge clk);
    chk(icr_rd == m_icr, {tag, " icr R2 R3 R4 R5"}, icr_rd, m_icr);
    chk(pcr_rd == m_pcr, {tag, " pcr R10"}, pcr_rd, m_pcr);
    chk(irq_pulse == m_pulse, {tag, " pulse R6 R7"}, {31'h0, irq_pulse}, {31'h0, m_pulse});
    chk(irq_master == m_icr[31], {tag, " master R5"}, {31'h0, irq_master}, {31'h0, m_icr[31]});
    chk(ch_start_go == go_model(m_pcr, rq), {tag, " go R8 R9"}, {25'h0, ch_start_go}, {25'h0, go_model(m_pcr, rq)});
    icr_wr = 1'b0; pcr_wr = 1'b0; ch_done = '0;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(icr_rd == 32'h0, "reset icr R1", icr_rd, 32'h0);
    chk(pcr_rd == 32'h0, "reset pcr R1", pcr_rd, 32'h0);
    chk(!irq_pulse, "reset pulse R1", {31'h0, irq_pulse}, 32'h0);
    ch_start_req = 7'h7F; #1;
    chk(ch_start_go == 7'h0, "reset go R1", {25'h0, ch_start_go}, 32'h0);
    ch_start_req = '0;
    rst_n = 1'b1;
    @(negedge clk);

    // R8 R9 R10: every enable pattern with all requests
    for (int p = 0; p < 128; p++) begin
      logic [31:0] w;
      w = {p[6:0], 25'h0} ^ 32'h5A5A_A5A5;
      for (int i = 0; i < 7; i++) w[4*i+3] = p[i];
      step(1'b0, 1'b1, w, 7'h0, 7'h7F, "pcr sweep");
    end
    // R8: every request pattern with all enables set
    step(1'b0, 1'b1, 32'hFFFF_FFFF, 7'h0, 7'h0, "pcr all");
    for (int r = 0; r < 128; r++) step(1'b0, 1'b0, 32'h0, 7'h0, r[6:0], "req sweep");

    // R2 masked write, force bit raises master (R6)
    step(1'b1, 1'b0, 32'hFFFF_FFFF, 7'h0, 7'h0, "all ones R2");
    step(1'b1, 1'b0, 32'h7F00_0000, 7'h0, 7'h0, "clear R2");

    // R3 R9: every enable pattern, global enable off, full completion burst
    for (int e = 0; e < 128; e++) begin
      step(1'b1, 1'b0, {1'b0, 7'h7F, 1'b0, e[6:0], 16'h0}, 7'h0, 7'h0, "en set R3");
      step(1'b0, 1'b0, 32'h0, 7'h7F, 7'h0, "burst R3 R9");
    end

    // R5 R6 R7 directed
    step(1'b1, 1'b0, 32'h7FFF_0000, 7'h0, 7'h0, "arm R5");
    step(1'b0, 1'b0, 32'h0, 7'h01, 7'h0, "first done R6");
    step(1'b0, 1'b0, 32'h0, 7'h04, 7'h0, "second done R7");
    step(1'b1, 1'b0, 32'h01FF_0000, 7'h0, 7'h0, "partial clear R7");
    step(1'b1, 1'b0, 32'h04FF_0000, 7'h0, 7'h0, "full clear R5");
    step(1'b1, 1'b0, 32'h02FF_0000, 7'h02, 7'h0, "set beats clear R4");
    step(1'b1, 1'b0, 32'h02FF_0000, 7'h0, 7'h0, "clear again R4");
    step(1'b1, 1'b0, 32'h00FF_8000, 7'h0, 7'h0, "force R5");
    step(1'b1, 1'b0, 32'h00FF_8000, 7'h08, 7'h0, "force hold R7");

    // mixed pseudo-random run
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] d;
      lfsr = nxt(lfsr); d = lfsr;
      lfsr = nxt(lfsr);
      step(lfsr[2:0] == 3'd0, lfsr[5:3] == 3'd0, d, lfsr[12:6] & {7{lfsr[13]}},
           lfsr[20:14], "random R3 R4 R5 R6 R7 R8");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule